// File: doc/BRIEF.md
# Phase-Shifted Multicarrier PWM Gate Generator

This block drives the four legs of one phase of a five-level inverter. The phase is built from two full-bridge cells in series. Every clock cycle the block compares a signed reference sample against four triangular carriers. All four carriers have the same amplitude and the same period, and each one is a quarter period behind the one before it. The comparator results set the leg commands. Each cell then adds +1, 0 or -1 to the phase output, so the sum of the two cells gives one of the five levels from -2 to +2.

All four carriers come from one shared phase counter. The half period `P` is set in clock cycles, and a full carrier period is `2P` cycles. Each carrier runs from `-P` to `+P`, so a reference of amplitude `A` gives a modulation index of `A/P`. The carrier frequency divided by the reference frequency is `f_clk / (2P)` divided by the rate at which the caller steps the reference. When enable is low, all legs are off and the carriers go back to their starting phases.

Top module: `pscpwm_top`

## Requirements
- R1: While reset is high, at the next clock edge `gate` becomes 0000, `level` becomes 0, and the phase counter becomes 0.
- R2: While `en` is low, the next clock edge sets `gate` to 0000 and `level` to 0, and resets the phase counter to 0. The first edge with `en` high therefore evaluates phase 0.
- R3: With latched half period `P`, the phase counter `ph` counts 0 to `2P-1` and then wraps to 0. Carrier k (k = 0..3) uses phase `q = (ph + k*P/2) mod 2P`. Its value is `2*t - P`, where `t = q` if `q < P` and `t = 2P - q` otherwise.
- R4: `half_period` is captured when `en` is low and on each edge where the counter wraps. It is held constant between those points. An odd value is rounded down to even, and any value below 2 is treated as 2.
- R5: The first leg of cell j (j = 0, 1) is on exactly when the reference is strictly greater than carrier j.
- R6: The second leg of cell j is on exactly when carrier j+2 is strictly greater than the reference.
- R7: `gate` bit order is: bit 0 = cell 0 first leg, bit 1 = cell 0 second leg, bit 2 = cell 1 first leg, bit 3 = cell 1 second leg.
- R8: `level` is a 3-bit two's-complement value equal to the sum over both cells of (first leg − second leg), in the range -2..+2.
- R9: Outputs are registered. The values after an edge are computed from `ref_in`, the counter phase and the latched period present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces legs off and restarts carriers |
| ref_in | input | REF_W | Signed reference sample, in carrier units |
| half_period | input | CNT_W | Carrier half period P in clock cycles |
| gate | output | 4 | Leg switch commands (order per R7) |
| level | output | 3 | Signed output level −2..+2 |

## Verification
Two things can happen on the same edge. The counter can wrap and capture a new half period, and the reference can step to a new value on that same cycle. The bench watches its own phase model. On exactly the wrap edge it changes `half_period` and flips the reference sign. It also drops and raises `en` in the middle of a period. A behavioural model then checks, cycle by cycle, that the new period takes effect only from phase 0 and that the new reference is used at that very edge.

// File: rtl/psc_pkg.sv
package psc_pkg;

    localparam int unsigned NUM_CELLS = 2;
    localparam int unsigned NUM_CARR  = 2 * NUM_CELLS;
    localparam int unsigned LVL_W     = 3;

    typedef logic signed [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic leg_a;
        logic leg_b;
    } cell_legs_t;

    function automatic lvl_t cell_contrib(cell_legs_t l);
        return lvl_t'({2'b00, l.leg_a}) - lvl_t'({2'b00, l.leg_b});
    endfunction

endpackage

// File: rtl/psc_phase_ctr.sv
module psc_phase_ctr #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] per_in,
    output logic [CNT_W-1:0] half_p,
    output logic [CNT_W:0]   ph
);

    logic [CNT_W-1:0] per_eff;
    logic [CNT_W:0]   full;

    assign per_eff = (per_in < CNT_W'(2)) ? CNT_W'(2) : {per_in[CNT_W-1:1], 1'b0};
    assign full    = {half_p, 1'b0};

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ph     <= '0;
            half_p <= per_eff;
        end else if (ph == full - (CNT_W+1)'(1)) begin
            ph     <= '0;
            half_p <= per_eff;
        end else begin
            ph     <= ph + (CNT_W+1)'(1);
        end
    end

    p_phase_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        ph < full);

    p_period_even_r4: assert property (@(posedge clk) disable iff (rst)
        (half_p[0] == 1'b0) && (half_p >= CNT_W'(2)));

    p_restart_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> (ph == '0));

endmodule

// File: rtl/psc_carrier.sv
module psc_carrier #(
    parameter int unsigned CNT_W = 10,
    parameter int unsigned IDX   = 0
) (
    input  logic [CNT_W:0]          ph,
    input  logic [CNT_W-1:0]        half_p,
    output logic signed [CNT_W+1:0] carr
);

    localparam int unsigned AW = CNT_W + 3;

    logic [AW-1:0]        off, sum, full2, q, tri_v;
    logic signed [AW-1:0] cw;

    assign off   = AW'(half_p >> 1) * AW'(IDX);
    assign sum   = AW'(ph) + off;
    assign full2 = AW'({half_p, 1'b0});
    assign q     = (sum >= full2) ? sum - full2 : sum;
    assign tri_v = (q < AW'(half_p)) ? q : full2 - q;
    assign cw    = $signed({tri_v[AW-2:0], 1'b0}) - $signed(AW'(half_p));
    assign carr  = cw[CNT_W+1:0];

endmodule

// File: rtl/psc_cell.sv
module psc_cell
    import psc_pkg::*;
#(
    parameter int unsigned CW = 14
) (
    input  logic signed [CW-1:0] ref_x,
    input  logic signed [CW-1:0] carr_a,
    input  logic signed [CW-1:0] carr_b,
    output cell_legs_t           legs
);

    always_comb begin
        legs.leg_a = ref_x > carr_a;
        legs.leg_b = carr_b > ref_x;
    end

endmodule

// File: rtl/pscpwm_top.sv
module pscpwm_top
    import psc_pkg::*;
#(
    parameter int unsigned CNT_W = 10,
    parameter int unsigned REF_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [REF_W-1:0] ref_in,
    input  logic [CNT_W-1:0]        half_period,
    output logic [NUM_CARR-1:0]     gate,
    output logic signed [LVL_W-1:0] level
);

    localparam int unsigned CMP_W = ((REF_W > CNT_W + 2) ? REF_W : CNT_W + 2) + 1;

    logic [CNT_W-1:0]        half_p;
    logic [CNT_W:0]          ph;
    logic signed [CNT_W+1:0] carr   [NUM_CARR];
    logic signed [CMP_W-1:0] carr_x [NUM_CARR];
    logic signed [CMP_W-1:0] ref_x;
    cell_legs_t              legs   [NUM_CELLS];
    lvl_t                    lvl_nxt;
    logic [NUM_CARR-1:0]     gate_nxt;

    psc_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst(rst), .en(en), .per_in(half_period),
        .half_p(half_p), .ph(ph)
    );

    assign ref_x = CMP_W'(ref_in);

    for (genvar k = 0; k < NUM_CARR; k++) begin : g_carr
        psc_carrier #(.CNT_W(CNT_W), .IDX(k)) u_carr (
            .ph(ph), .half_p(half_p), .carr(carr[k])
        );
        assign carr_x[k] = CMP_W'(carr[k]);
    end

    for (genvar j = 0; j < NUM_CELLS; j++) begin : g_cell
        psc_cell #(.CW(CMP_W)) u_cell (
            .ref_x(ref_x), .carr_a(carr_x[j]), .carr_b(carr_x[j+NUM_CELLS]),
            .legs(legs[j])
        );
        assign gate_nxt[2*j]   = legs[j].leg_a;
        assign gate_nxt[2*j+1] = legs[j].leg_b;
    end

    always_comb begin
        lvl_nxt = '0;
        for (int j = 0; j < NUM_CELLS; j++) begin
            lvl_nxt = lvl_nxt + cell_contrib(legs[j]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            gate  <= '0;
            level <= '0;
        end else begin
            gate  <= gate_nxt;
            level <= lvl_nxt;
        end
    end

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> (gate == '0) && (level == '0));

    p_mirror_pairs_r3: assert property (@(posedge clk) disable iff (rst)
        (carr[0] == -carr[2]) && (carr[1] == -carr[3]));

    p_level_sum_r8: assert property (@(posedge clk) disable iff (rst)
        level == ($signed({2'b00, gate[0]}) - $signed({2'b00, gate[1]})
                + $signed({2'b00, gate[2]}) - $signed({2'b00, gate[3]})));

endmodule

// File: tb/tb_pscpwm_top.sv
module tb_pscpwm_top;

    localparam int CNT_W = 10;
    localparam int REF_W = 12;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    en  = 1'b0;
    logic signed [REF_W-1:0] ref_in = '0;
    logic [CNT_W-1:0]        half_period = 10'd8;
    logic [3:0]              gate;
    logic signed [2:0]       level;

    int checks = 0;
    int failures = 0;
    string cur_tag = "R1";

    int m_ph = 0;
    int m_p  = 8;
    int exp_g = 0;
    int exp_l = 0;

    always #2.5 clk = ~clk;

    pscpwm_top #(.CNT_W(CNT_W), .REF_W(REF_W)) dut (
        .clk(clk), .rst(rst), .en(en), .ref_in(ref_in),
        .half_period(half_period), .gate(gate), .level(level)
    );

    function automatic int eff_per(int v);
        return (v < 2) ? 2 : (v - (v % 2));
    endfunction

    function automatic int carrier(int ph, int p, int k);
        int q, t;
        q = (ph + k * (p / 2)) % (2 * p);
        t = (q < p) ? q : 2 * p - q;
        return 2 * t - p;
    endfunction

    // reference model, evaluated at each rising edge
    always @(posedge clk) begin
        int r, a0, b0, a1, b1;
        if (rst || !en) begin
            exp_g = 0; exp_l = 0; m_ph = 0; m_p = eff_per(int'(half_period));
        end else begin
            r  = int'(ref_in);
            a0 = (r > carrier(m_ph, m_p, 0)) ? 1 : 0;
            b0 = (carrier(m_ph, m_p, 2) > r) ? 1 : 0;
            a1 = (r > carrier(m_ph, m_p, 1)) ? 1 : 0;
            b1 = (carrier(m_ph, m_p, 3) > r) ? 1 : 0;
            exp_g = a0 | (b0 << 1) | (a1 << 2) | (b1 << 3);
            exp_l = a0 - b0 + a1 - b1;
            if (m_ph == 2 * m_p - 1) begin
                m_ph = 0; m_p = eff_per(int'(half_period));
            end else begin
                m_ph = m_ph + 1;
            end
        end
    end

    task automatic compare_now();
        checks++;
        if (int'(gate) != exp_g) begin
            failures++;
            $display("FAIL R5 R6 R7 [%s] gate got=%b exp=%b", cur_tag, gate, 4'(exp_g));
        end
        checks++;
        if (int'(level) != exp_l) begin
            failures++;
            $display("FAIL R8 [%s] level got=%0d exp=%0d", cur_tag, int'(level), exp_l);
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare_now();
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #500000;
        failures++;
        $display("FAIL watchdog expired got=running exp=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_tag = "R1";
        repeat (3) step();
        checks++;
        if (gate != 4'b0000 || level != 3'sd0) begin
            failures++;
            $display("FAIL R1 reset got=%b/%0d exp=0000/0", gate, int'(level));
        end
        rst = 1'b0;
        step();

        // R3: carrier shapes with zero and slow-swept reference
        cur_tag = "R3";
        en = 1'b1;
        ref_in = '0;
        repeat (40) step();
        for (int i = 0; i < 300; i++) begin
            int w;
            w = i % 40;
            ref_in = REF_W'((w < 20) ? w - 10 : 30 - w);
            step();
        end

        // R8: reference beyond band saturates level at +2 / -2
        cur_tag = "R8";
        ref_in = 12'sd9;
        repeat (20) step();
        checks++;
        if (level != 3'sd2) begin
            failures++;
            $display("FAIL R8 saturate got=%0d exp=2", int'(level));
        end
        ref_in = -12'sd9;
        repeat (20) step();
        checks++;
        if (level != -3'sd2) begin
            failures++;
            $display("FAIL R8 saturate got=%0d exp=-2", int'(level));
        end

        // R9: reference flips every cycle, used at the very next edge
        cur_tag = "R9";
        for (int i = 0; i < 40; i++) begin
            ref_in = (i % 2 == 0) ? 12'sd5 : -12'sd3;
            step();
        end

        // R4: odd, tiny and large periods, changed mid-period
        cur_tag = "R4";
        half_period = 10'd7;
        for (int i = 0; i < 120; i++) begin ref_in = REF_W'((i % 13) - 6); step(); end
        half_period = 10'd1;
        for (int i = 0; i < 60; i++) begin ref_in = REF_W'((i % 5) - 2); step(); end
        half_period = 10'd0;
        for (int i = 0; i < 30; i++) begin ref_in = REF_W'((i % 3) - 1); step(); end
        half_period = 10'd100;
        for (int i = 0; i < 600; i++) begin ref_in = REF_W'((i % 220) - 110); step(); end

        // R2: disable in mid period, then resume from phase 0
        cur_tag = "R2";
        half_period = 10'd12;
        ref_in = 12'sd4;
        repeat (37) step();
        en = 1'b0;
        repeat (5) begin
            step();
            checks++;
            if (gate != 4'b0000 || level != 3'sd0) begin
                failures++;
                $display("FAIL R2 idle got=%b/%0d exp=0000/0", gate, int'(level));
            end
        end
        en = 1'b1;
        repeat (60) step();

        // coincident: new period and reference step on the wrap edge
        cur_tag = "R4 wrap";
        for (int n = 0; n < 6; n++) begin
            while (m_ph != 2 * m_p - 1) step();
            half_period = CNT_W'(6 + 4 * n);
            ref_in = (n % 2 == 0) ? -12'sd7 : 12'sd7;
            step();
        end
        repeat (80) step();

        finish_run();
    end

endmodule